// File: doc/BRIEF.md
# Borrow-Flag Countdown Delay Timer

This block produces a programmable delay measured in clock cycles. A start strobe loads a count into a down-counter, which then steps down by one on every rising clock edge. The counter carries one bit more than the count needs. That extra top bit is cleared at load and is set by the borrow when the counter steps below zero. The end of the delay is taken from that single bit alone, so no equality comparator against a target value sits on the terminal path. The carry chain of the decrementer does the terminal detection, and the timer stays fast at 30 bits and beyond.

The count comes from one of two places. It can be the `load_val_i` port at run time, or the compile-time parameter `DEF_COUNT` when `use_def_i` is high. While a delay runs, `busy_o` is high. When the delay ends, `done_o` pulses for one cycle and the counter then stays parked until the next start. All pins are plain control and status levels. No data stream crosses the block's edge, so it has no valid/ready handshake.

Top module: `dly_timer`

## Requirements
- R1: While `rst` is high on a rising edge, and in the cycle after it, `busy_o` and `done_o` are 0.
- R2: If `start_i` is high with `use_def_i` = 0 on a rising edge and the load value is N, then `done_o` is high in the cycle that follows the (N+1)-th rising edge after that start edge, and not before.
- R3: If `start_i` is high with `use_def_i` = 1, the count loaded is the parameter `DEF_COUNT` and `load_val_i` is ignored, so `done_o` comes DEF_COUNT+1 edges after the start.
- R4: `busy_o` is high from the edge that takes a start until the edge at which the counter underflows. It is low in the cycle in which `done_o` is high.
- R5: `done_o` is high for exactly one cycle per completed delay. After that the timer stays idle, with `busy_o` = 0 and no further `done_o`, until the next start.
- R6: A start while `busy_o` is high discards the running delay and times the new count from that edge. The old count produces no `done_o`.
- R7: A load value of 0 makes `done_o` rise in the cycle after the first edge that follows the start edge, which is one clock after the start.
- R8: A reset during a running delay aborts it. No `done_o` follows unless a new start arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. All state changes on its rising edge only. |
| rst | input | 1 | Synchronous reset, active high. |
| start_i | input | 1 | Load strobe. Starts or restarts a delay. |
| use_def_i | input | 1 | 1: load `DEF_COUNT`; 0: load `load_val_i`. |
| load_val_i | input | VAL_W | Run-time delay count. |
| busy_o | output | 1 | A delay is in progress. |
| done_o | output | 1 | One-cycle pulse when the delay ends. |

## Verification
The bench goes after these corner cases:
- A zero count. A design that compared against a terminal value, or skipped the final borrow step, would fire on the start edge itself or one cycle late.
- A restart in mid-delay. This exposes a timer that finishes the stale count or drops the new one.
- Long idle stretches after a pulse. A counter that kept wrapping would emit a second `done_o` there.
- A reset in mid-delay, and a start with the default count selected while the port carries an unrelated value. These show up a stale pulse and a wrong count source respectively.

Random starts, counts and source selections are checked cycle by cycle against a bench model of the remaining count.

// File: rtl/dly_pkg.sv
package dly_pkg;
  typedef enum logic {
    SRC_PORT  = 1'b0,
    SRC_PARAM = 1'b1
  } dly_src_e;
endpackage

// File: rtl/dly_src_sel.sv
module dly_src_sel #(
  parameter int VAL_W     = 20,
  parameter int DEF_COUNT = 100
) (
  input  logic             use_def_i,
  input  logic [VAL_W-1:0] port_val_i,
  output logic [VAL_W-1:0] val_o
);
  import dly_pkg::*;
  localparam logic [VAL_W-1:0] DEF_VAL = VAL_W'(DEF_COUNT);

  dly_src_e src;
  assign src = dly_src_e'(use_def_i);

  always_comb begin
    case (src)
      SRC_PARAM: val_o = DEF_VAL;
      default:   val_o = port_val_i;
    endcase
  end
endmodule

// File: rtl/dly_down_cnt.sv
module dly_down_cnt #(
  parameter int VAL_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [VAL_W-1:0] val_i,
  output logic             under_o
);
  localparam int CNT_W = VAL_W + 1;
  localparam logic [CNT_W-1:0] PARKED = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= PARKED;
    else if (load_i)
      cnt <= {1'b0, val_i};
    else if (!cnt[CNT_W-1])
      cnt <= cnt - CNT_W'(1);
  end

  assign under_o = cnt[CNT_W-1];

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    load_i |=> !under_o) else $error("load must clear flag"); // R2

  AST_PARKED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (under_o && !load_i) |=> under_o) else $error("parked counter moved"); // R5
endmodule

// File: rtl/dly_expiry.sv
module dly_expiry (
  input  logic clk,
  input  logic rst,
  input  logic under_i,
  output logic busy_o,
  output logic done_o
);
  logic under_q;

  always_ff @(posedge clk) begin
    if (rst) under_q <= 1'b1;
    else     under_q <= under_i;
  end

  assign busy_o = ~under_i;
  assign done_o = under_i & ~under_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o) else $error("done longer than one cycle"); // R5

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o))) else $error("done without busy"); // R4
endmodule

// File: rtl/dly_timer.sv
module dly_timer #(
  parameter int VAL_W     = 20,
  parameter int DEF_COUNT = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             use_def_i,
  input  logic [VAL_W-1:0] load_val_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [VAL_W-1:0] sel_val;
  logic             under;

  dly_src_sel #(.VAL_W(VAL_W), .DEF_COUNT(DEF_COUNT)) u_sel (
    .use_def_i (use_def_i),
    .port_val_i(load_val_i),
    .val_o     (sel_val)
  );

  dly_down_cnt #(.VAL_W(VAL_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .load_i (start_i),
    .val_i  (sel_val),
    .under_o(under)
  );

  dly_expiry u_exp (
    .clk    (clk),
    .rst    (rst),
    .under_i(under),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (busy_o && !done_o)) else $error("start not taken"); // R6

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> (!busy_o && !done_o)) else $error("idle left"); // R5

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!busy_o && !done_o)) else $error("reset not quiet"); // R1
endmodule

// File: tb/sim_dly_timer.sv
module sim_dly_timer;
  localparam int W   = 20;
  localparam int DEF = 37;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic sel = 1'b0;
  logic [W-1:0] val = '0;
  logic busy, done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int  m_rem  = 0;
  logic m_busy = 1'b0;
  logic m_done = 1'b0;

  always #10 clk = ~clk;

  dly_timer #(.VAL_W(W), .DEF_COUNT(DEF)) u0 (
    .clk(clk), .rst(rst), .start_i(start), .use_def_i(sel),
    .load_val_i(val), .busy_o(busy), .done_o(done)
  );

  function automatic int pick_count(logic s, logic [W-1:0] v);
    return s ? DEF : int'(v);
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      m_busy <= 1'b0; m_done <= 1'b0; m_rem <= 0;
    end else if (start) begin
      m_busy <= 1'b1; m_done <= 1'b0; m_rem <= pick_count(sel, val);
    end else if (m_busy) begin
      if (m_rem == 0) begin m_busy <= 1'b0; m_done <= 1'b1; end
      else begin m_rem <= m_rem - 1; m_done <= 1'b0; end
    end else
      m_done <= 1'b0;
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic tick(logic st, logic [W-1:0] v, logic s);
    start = st; val = v; sel = s;
    @(posedge clk);
    @(negedge clk);
    chk("R4 busy vs model", int'(busy), int'(m_busy));
    chk("R2 done vs model", int'(done), int'(m_done));
  endtask

  task automatic wait_done(output int n);
    n = 0;
    do begin
      tick(1'b0, '0, 1'b0);
      n++;
    end while (!done && n < 5000);
  endtask

  initial begin
    if (cycles > 150000) $display("unreachable");
  end

  always @(posedge clk) begin
    if (cycles == 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int pulses;
    void'($urandom(32'd2024));
    // R1: reset state
    @(posedge clk); @(negedge clk);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 done in reset", int'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);

    // R7: zero count
    tick(1'b1, '0, 1'b0);
    chk("R7 busy after start", int'(busy), 1);
    chk("R7 no done on start edge", int'(done), 0);
    tick(1'b0, '0, 1'b0);
    chk("R7 done one clock later", int'(done), 1);
    chk("R7 busy drops", int'(busy), 0);

    // R2: runtime count 5 -> done after 6 edges
    tick(1'b1, W'(5), 1'b0);
    wait_done(n);
    chk("R2 delay edges for 5", n, 6);

    // R3: default count, port value ignored
    tick(1'b1, W'(3), 1'b1);
    wait_done(n);
    chk("R3 delay edges for default", n, DEF + 1);

    // R5: no rewrap after done
    pulses = 0;
    repeat (60) begin
      tick(1'b0, '0, 1'b0);
      if (done) pulses++;
      chk("R5 idle busy", int'(busy), 0);
    end
    chk("R5 extra pulses", pulses, 0);

    // R6: restart mid-delay
    tick(1'b1, W'(20), 1'b0);
    repeat (8) tick(1'b0, '0, 1'b0);
    tick(1'b1, W'(4), 1'b0);
    wait_done(n);
    chk("R6 restarted delay edges", n, 5);
    pulses = 0;
    repeat (30) begin tick(1'b0, '0, 1'b0); if (done) pulses++; end
    chk("R6 stale count pulses", pulses, 0);

    // R8: reset aborts
    tick(1'b1, W'(10), 1'b0);
    repeat (3) tick(1'b0, '0, 1'b0);
    rst = 1'b1;
    tick(1'b0, '0, 1'b0);
    chk("R8 busy cleared", int'(busy), 0);
    rst = 1'b0;
    pulses = 0;
    repeat (20) begin tick(1'b0, '0, 1'b0); if (done) pulses++; end
    chk("R8 no pulse after abort", pulses, 0);

    // long count
    tick(1'b1, W'(3000), 1'b0);
    wait_done(n);
    chk("R2 delay edges for 3000", n, 3001);

    // random mix, checked per cycle against the model
    for (int i = 0; i < 4000; i++) begin
      logic st;
      st = ($urandom % 8) == 0;
      tick(st, W'($urandom % 24), ($urandom % 4) == 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule